// File: doc/BRIEF.md
# Burst Cycle and Address Sequencer

This block is the synchronous control front end of a burst-capable SRAM. It registers the strobes, the advance input, the three chip enables, the write controls and the full word address on each rising clock edge. From them it picks the operation for that cycle: deselect, begin a burst, continue it, or suspend it. It also works out whether the cycle reads or writes and which byte lanes are written.

The word address comes from a loaded base and a 2-bit burst counter. Only the two low address bits follow the burst sequence. The sequence is either linear (incrementing with wrap) or interleaved (XOR with the count). The order input is captured when a burst begins. The storage array and the data path are outside this block. They consume the registered address, the operation code, the write flag, the lane write vector and the selected flag.

There are two strobes. The processor strobe always starts a read, and it is ignored while the first enable is inactive. The controller strobe starts a read or a write depending on the write controls. A new address can be loaded on every cycle, so the block also serves plain single-word access.

Top module: `sram_burst_seq`

## Requirements
- R1: After a synchronous reset the outputs show a deselect cycle: `op_o` = 0, `selected_o` low, `write_o` low, `lane_we_o` zero and `word_addr_o` zero.
- R2: When the processor strobe is low, `en1_n` is low, `en2` is high and `en3_n` is low, the next outputs show a begin cycle (`op_o` = 1) at the sampled address. The cycle is a read (`write_o` low, `lane_we_o` zero) whatever the write controls are.
- R3: When the controller strobe starts a cycle, the write controls decide its direction. With `gwr_n` low, every lane is written. Otherwise, with `bwr_n` low, lane i is written when `lane_n[i]` is low. Otherwise the cycle is a read. `write_o` is high exactly when `lane_we_o` is non-zero.
- R4: While `en1_n` is high, a low processor strobe is ignored. With the controller strobe high during a burst, the cycle continues or suspends as the advance input directs.
- R5: A cycle where an acting strobe is low but the enables are not all true is a deselect (`op_o` = 0, `selected_o` low), and it ends any burst in progress.
- R6: With no acting strobe and `adv_n` low during a burst, the cycle is a continue (`op_o` = 2). The low two address bits step once, and the upper bits keep their loaded value.
- R7: With `ilv_order` low at load, the low bits run S, S+1, S+2, S+3 modulo 4. With it high, they run S XOR 0, S XOR 1, S XOR 2, S XOR 3.
- R8: The fourth continue of a burst brings the low bits back to the start value S.
- R9: With no acting strobe and `adv_n` high during a burst, the cycle is a suspend (`op_o` = 3). The address stays the same, and the write controls decide read or write.
- R10: After a deselect, continue and suspend requests stay deselected until a strobe loads a new address.
- R11: Strobes on consecutive cycles load a fresh address each cycle. Each such cycle is a begin at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pstrb_n | input | 1 | Processor address strobe, active low, always read |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Chip enable, active low; also masks the processor strobe |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| gwr_n | input | 1 | Write all lanes, active low |
| bwr_n | input | 1 | Lane write qualifier, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| addr_i | input | AW | Word address to load |
| ilv_order | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| word_addr_o | output | AW | Effective word address of the current cycle |
| op_o | output | 2 | 0 deselect, 1 begin, 2 continue, 3 suspend |
| write_o | output | 1 | Current cycle writes |
| lane_we_o | output | LANES | Lanes written in the current cycle |
| selected_o | output | 1 | Chip selected this cycle |

## Verification
If the burst-active flag is wrong, it shows on the first strobe-free cycle after a deselect: `op_o` reports continue or suspend where deselect is expected, or the reverse. If the count or the captured order is wrong, `word_addr_o` differs from the expected sequence on the very next continue. The wrap error only appears on the fourth step. If the decode of strobe or mask is wrong, it appears one edge later as a wrong `op_o` or write direction. All outputs are registered, so every fault shows one clock after the inputs that trigger it.

// File: rtl/sram_burst_pkg.sv
// Shared types for the burst sequencer.
package sram_burst_pkg;
    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_BEGIN = 2'd1,
        OP_CONT  = 2'd2,
        OP_SUSP  = 2'd3
    } burst_op_t;
endpackage

// File: rtl/sram_lane_decode.sv
// Lane write decode: turns the global and lane-qualified write controls
// into a per-lane write vector. Purely combinational; assumes inputs are
// already the sampled values for the cycle.
module sram_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we,
    output logic             any_we
);
    // Pick the lane vector from the write controls.
    always_comb begin
        if (!gwr_n)      lane_we = '1;
        else if (!bwr_n) lane_we = ~lane_n;
        else             lane_we = '0;
        any_we = |lane_we;
    end

    // Global write must reach every lane.
    always_comb begin
        if (!gwr_n) AST_GLOBAL_ALL: assert (&lane_we); // R3
    end
endmodule

// File: rtl/sram_cmd_decode.sv
// Cycle command decode: derives this cycle's operation, the load and step
// controls for the address counter, and the direction. Assumes burst_act
// is the registered "a burst is open" flag from the top.
module sram_cmd_decode
    import sram_burst_pkg::*;
(
    input  logic      pstrb_n,
    input  logic      cstrb_n,
    input  logic      adv_n,
    input  logic      en1_n,
    input  logic      en2,
    input  logic      en3_n,
    input  logic      wr_req,
    input  logic      burst_act,
    output burst_op_t op_nxt,
    output logic      load,
    output logic      step,
    output logic      wr_nxt
);
    logic en_ok, p_go, c_go;

    // Enables and strobe qualification (first enable masks processor strobe).
    always_comb begin
        en_ok = !en1_n && en2 && !en3_n;
        p_go  = !pstrb_n && !en1_n;
        c_go  = !cstrb_n;
    end

    // Operation selection by strobe, then burst state and advance.
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        wr_nxt = 1'b0;
        op_nxt = OP_DESEL;
        if (p_go || c_go) begin
            if (en_ok) begin
                op_nxt = OP_BEGIN;
                load   = 1'b1;
                wr_nxt = p_go ? 1'b0 : wr_req;
            end
        end else if (burst_act) begin
            wr_nxt = wr_req;
            if (!adv_n) begin
                op_nxt = OP_CONT;
                step   = 1'b1;
            end else begin
                op_nxt = OP_SUSP;
            end
        end
    end

    // Load and step never coincide.
    always_comb begin
        AST_LOAD_STEP_EXCL: assert (!(load && step)); // R6
    end
endmodule

// File: rtl/sram_burst_counter.sv
// Burst address generator: holds the loaded upper address, the start value
// of the low two bits, the captured order, and a 2-bit count. The low bits
// are start+count (linear) or start^count (interleaved).
module sram_burst_counter #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_i,
    input  logic          ilv_i,
    output logic [AW-1:0] addr_o
);
    localparam int UW = AW - 2;

    logic [UW-1:0] upper_q;
    logic [1:0]    start_q;
    logic [1:0]    cnt_q;
    logic          ilv_q;
    logic [1:0]    low;

    // Capture base and order on load, count on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b0;
        end else if (load) begin
            upper_q <= addr_i[AW-1:2];
            start_q <= addr_i[1:0];
            cnt_q   <= '0;
            ilv_q   <= ilv_i;
        end else if (step) begin
            cnt_q   <= cnt_q + 2'd1;
        end
    end

    // Combine count and start in the captured order.
    always_comb begin
        low    = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
        addr_o = {upper_q, low};
    end

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !ilv_q) |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1)); // R7

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> $stable(addr_o[AW-1:2])); // R6
endmodule

// File: rtl/sram_burst_seq.sv
// Burst cycle and address sequencer top: registers the decoded operation,
// direction, lane writes and address for the data path. Assumes all
// control inputs are synchronous to clk.
module sram_burst_seq
    import sram_burst_pkg::*;
#(
    parameter int AW    = 19,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             adv_n,
    input  logic             en1_n,
    input  logic             en2,
    input  logic             en3_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             ilv_order,
    output logic [AW-1:0]    word_addr_o,
    output logic [1:0]       op_o,
    output logic             write_o,
    output logic [LANES-1:0] lane_we_o,
    output logic             selected_o
);
    logic [LANES-1:0] lane_we;
    logic             any_we;
    burst_op_t        op_nxt, op_q;
    logic             load, step, wr_nxt;
    logic             act_q;

    sram_lane_decode #(.LANES(LANES)) u_lane (
        .gwr_n   (gwr_n),
        .bwr_n   (bwr_n),
        .lane_n  (lane_n),
        .lane_we (lane_we),
        .any_we  (any_we)
    );

    sram_cmd_decode u_cmd (
        .pstrb_n   (pstrb_n),
        .cstrb_n   (cstrb_n),
        .adv_n     (adv_n),
        .en1_n     (en1_n),
        .en2       (en2),
        .en3_n     (en3_n),
        .wr_req    (any_we),
        .burst_act (act_q),
        .op_nxt    (op_nxt),
        .load      (load),
        .step      (step),
        .wr_nxt    (wr_nxt)
    );

    sram_burst_counter #(.AW(AW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .addr_i (addr_i),
        .ilv_i  (ilv_order),
        .addr_o (word_addr_o)
    );

    // Register the cycle's operation, direction and lane writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_DESEL;
            act_q     <= 1'b0;
            write_o   <= 1'b0;
            lane_we_o <= '0;
        end else begin
            op_q      <= op_nxt;
            act_q     <= (op_nxt != OP_DESEL);
            write_o   <= wr_nxt;
            lane_we_o <= wr_nxt ? lane_we : '0;
        end
    end

    // Present the registered operation to the data path.
    always_comb begin
        op_o       = op_q;
        selected_o = act_q;
    end

    AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n && !en1_n && en2 && !en3_n) |=> (op_o == OP_BEGIN && !write_o)); // R2

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o != OP_DESEL && cstrb_n && (pstrb_n || en1_n) && adv_n)
        |=> (op_o == OP_SUSP && $stable(word_addr_o))); // R9

    AST_DESEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_DESEL && cstrb_n && (pstrb_n || en1_n)) |=> (op_o == OP_DESEL)); // R10

    AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        write_o == (lane_we_o != '0)); // R3
endmodule

// File: tb/sram_burst_seq_test.sv
module sram_burst_seq_test;
    localparam int AW = 19;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
    logic en1_n = 1'b0, en2 = 1'b1, en3_n = 1'b0;
    logic gwr_n = 1'b1, bwr_n = 1'b1;
    logic [LANES-1:0] lane_n = '1;
    logic [AW-1:0] addr_i = '0;
    logic ilv_order = 1'b0;
    logic [AW-1:0] word_addr_o;
    logic [1:0] op_o;
    logic write_o;
    logic [LANES-1:0] lane_we_o;
    logic selected_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sram_burst_seq #(.AW(AW), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
        .adv_n(adv_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .addr_i(addr_i),
        .ilv_order(ilv_order), .word_addr_o(word_addr_o), .op_o(op_o),
        .write_o(write_o), .lane_we_o(lane_we_o), .selected_o(selected_o)
    );

    task automatic chk(string req, logic [1:0] op, logic wr, logic [AW-1:0] a,
                       logic [LANES-1:0] we);
        checks++;
        if (op_o !== op || write_o !== wr || word_addr_o !== a || lane_we_o !== we ||
            selected_o !== (op != 2'd0)) begin
            errors++;
            $display("FAIL %s: op=%0d wr=%0b addr=%h we=%b sel=%0b expected op=%0d wr=%0b addr=%h we=%b",
                     req, op_o, write_o, word_addr_o, lane_we_o, selected_o, op, wr, a, we);
        end
    endtask

    task automatic chk_op(string req, logic [1:0] op);
        checks++;
        if (op_o !== op || selected_o !== (op != 2'd0)) begin
            errors++;
            $display("FAIL %s: op=%0d sel=%0b expected op=%0d", req, op_o, selected_o, op);
        end
    endtask

    // Drive one cycle at the falling edge; results are sampled after the next rise.
    task automatic drive(logic p, logic c, logic adv, logic e1, logic e2v, logic e3,
                         logic gw, logic bw, logic [LANES-1:0] ln, logic [AW-1:0] a);
        @(negedge clk);
        pstrb_n = p; cstrb_n = c; adv_n = adv; en1_n = e1; en2 = e2v; en3_n = e3;
        gwr_n = gw; bwr_n = bw; lane_n = ln; addr_i = a;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_read(logic adv);
        drive(1, 1, adv, 0, 1, 0, 1, 1, '1, '0);
    endtask

    task automatic t_reset;
        chk("R1 reset", 2'd0, 0, '0, '0);
    endtask

    task automatic t_proc_read;
        logic [AW-1:0] a = 19'h12346;
        drive(0, 1, 1, 0, 1, 0, 0, 0, 4'b0000, a);
        chk("R2 proc strobe read", 2'd1, 0, a, '0);
    endtask

    task automatic t_order(logic ilv, logic [1:0] s, string rq);
        logic [AW-1:0] a = {17'h0ABCD, s};
        @(negedge clk); ilv_order = ilv;
        drive(1, 0, 1, 0, 1, 0, 1, 1, '1, a);
        chk({rq, " load"}, 2'd1, 0, a, '0);
        for (int k = 1; k <= 4; k++) begin
            logic [1:0] lo = ilv ? (s ^ 2'(k)) : 2'(s + 2'(k));
            idle_read(0);
            if (k == 4) chk("R8 wrap to start", 2'd2, 0, a, '0);
            else        chk({rq, " R6 step"}, 2'd2, 0, {a[AW-1:2], lo}, '0);
        end
        @(negedge clk); ilv_order = 1'b0;
    endtask

    task automatic t_ctrl_write;
        logic [AW-1:0] a = 19'h00F05;
        drive(1, 0, 1, 0, 1, 0, 1, 0, 4'b1010, a);
        chk("R3 lane write", 2'd1, 1, a, 4'b0101);
        drive(1, 0, 1, 0, 1, 0, 0, 1, 4'b1111, a + 1);
        chk("R3 global write", 2'd1, 1, a + 1, 4'b1111);
        drive(1, 0, 1, 0, 1, 0, 1, 1, 4'b0000, a + 2);
        chk("R3 no write qualifier reads", 2'd1, 0, a + 2, '0);
    endtask

    task automatic t_suspend;
        logic [AW-1:0] a = 19'h20001;
        drive(1, 0, 1, 0, 1, 0, 1, 1, '1, a);
        drive(1, 1, 1, 0, 1, 0, 0, 1, '1, '0);
        chk("R9 suspend write", 2'd3, 1, a, 4'b1111);
        idle_read(1);
        chk("R9 suspend read", 2'd3, 0, a, '0);
    endtask

    task automatic t_mask;
        logic [AW-1:0] a = 19'h30002;
        drive(1, 0, 1, 0, 1, 0, 1, 1, '1, a);
        drive(0, 1, 0, 1, 1, 0, 1, 1, '1, 19'h7FFFF);
        chk("R4 masked strobe continues", 2'd2, 0, a + 1, '0);
    endtask

    task automatic t_disable;
        logic [AW-1:0] a = 19'h40000;
        drive(1, 0, 1, 0, 1, 0, 1, 1, '1, a);
        drive(1, 0, 0, 0, 0, 0, 1, 1, '1, a + 8);
        chk_op("R5 enables false deselect", 2'd0);
        idle_read(0);
        chk_op("R10 continue stays deselected", 2'd0);
        idle_read(1);
        chk_op("R10 suspend stays deselected", 2'd0);
        drive(0, 1, 1, 1, 1, 0, 1, 1, '1, a);
        chk_op("R4 masked strobe no load while idle", 2'd0);
        drive(0, 1, 1, 0, 1, 0, 1, 1, '1, a + 4);
        chk("R10 strobe reloads", 2'd1, 0, a + 4, '0);
    endtask

    task automatic t_b2b;
        for (int i = 0; i < 3; i++) begin
            logic [AW-1:0] a = 19'h51230 + 19'(i * 7);
            drive(1, 0, 0, 0, 1, 0, 1, 1, '1, a);
            chk("R11 back-to-back load", 2'd1, 0, a, '0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_proc_read();
        t_order(0, 2'd1, "R7 linear");
        t_order(1, 2'd2, "R7 interleaved");
        t_ctrl_write();
        t_suspend();
        t_mask();
        t_disable();
        t_b2b();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule